// File: doc/BRIEF.md
# Serial Memory Read Slave

This block is the slave end of a byte-organised serial static memory that can only be read. A master lowers chip select, clocks in a one-byte command and a three-byte address, and then keeps clocking to receive bytes from an internal array, one after another, for as long as chip select stays low. The link carries one, two or four bits per clock. A static mode input picks the width, and that width applies to the command, the address and the data.

Only the low 17 bits of the address select a byte. The pointer steps up by one after every byte and wraps from the top of the 17-bit space to zero. In the two wider modes a fixed number of idle clocks sits between the address and the first data bits, so the master has time to turn its lines around. Outputs come as a four-bit data vector with a matching per-lane drive enable, and a pad ring can build tri-state pins from them. A preload port, clocked by the serial clock while chip select is high, fills the array.

Top module: `serial_mem_reader`

## Requirements
- R1: While chip select is high or reset is low, every bit of `dq_oe` is 0. Chip select going high clears the command, address and counting state at once, so the next low period starts a fresh transaction.
- R2: The first eight bits of a transaction form the command, most significant bit first. 0x03 starts a read. Any other code leaves `dq_oe` at 0 until chip select rises, however many clocks follow.
- R3: The command is followed by a 24-bit address, most significant bit first. Its top 7 bits have no effect, and the byte read is the one at the low 17 bits.
- R4: With `mode_sel` 0 (and also 3), one bit per clock enters on `dq_in[0]` and `dq_in[3:1]` are ignored. Data leaves on `dq_out[1]` with `dq_oe` = 4'b0010, and there are no idle clocks: the first data bit appears on the falling edge that follows the rising edge which samples the last address bit.
- R5: With `mode_sel` 1, two bits per clock use lanes [1:0], with lane 1 carrying the more significant bit, and `dq_in[3:2]` are ignored. Four clocks with `dq_oe` = 0 follow the address, and the data is then driven with `dq_oe` = 4'b0011.
- R6: With `mode_sel` 2, four bits per clock use lanes [3:0], with lane 3 the most significant. Two clocks with `dq_oe` = 0 follow the address, and the data is then driven with `dq_oe` = 4'b1111.
- R7: Data bytes are sent most significant bit first. After each complete byte the pointer steps up by one, so consecutive bytes come from consecutive addresses.
- R8: After the byte at address 0x1FFFF, the next byte comes from address 0x00000.
- R9: The array holds `DEPTH` bytes, where `DEPTH` is a power of two. The 17-bit address selects byte (address mod `DEPTH`). A preload with `pl_we` high is written on the rising edge of `sclk`.
- R10: Input lanes are sampled on the rising edge of `sclk`. `dq_out` and `dq_oe` change only on the falling edge of `sclk` or when chip select rises.
- R11: Raising chip select in the middle of a data byte ends the read at once, and the next transaction behaves exactly as one that follows a completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select; high ends and clears a transaction |
| mode_sel | input | 2 | Link width: 0 one lane, 1 two lanes, 2 four lanes, 3 one lane |
| dq_in | input | 4 | Serial data lanes from the master |
| dq_out | output | 4 | Serial data lanes to the master |
| dq_oe | output | 4 | Per-lane drive enable for `dq_out` |
| pl_we | input | 1 | Preload write strobe |
| pl_idx | input | $clog2(DEPTH) | Preload array index |
| pl_data | input | 8 | Preload byte |

## Verification
The bench uses the default `DEPTH` of 1024. The 17-bit space therefore mirrors the array 128 times, so reads that start near 0x1FFFF, or that carry junk in the top address bits, still land on preloaded bytes whose values the bench knows. With this depth the bench can also fill the whole array with random content in about a thousand clocks. That leaves room for many short random reads in all three link widths, as well as directed cases on the wrap, on bad commands and on mid-byte aborts. A pointer that wraps wrongly inside the mirrored range cannot be seen at the ports, so the clocked properties on the pointer cover that case.

// File: rtl/smr_pkg.sv
`timescale 1ns/1ps
package smr_pkg;

    typedef enum logic [1:0] {
        LINK_X1 = 2'd0,
        LINK_X2 = 2'd1,
        LINK_X4 = 2'd2
    } link_e;

    typedef enum logic [2:0] {
        PH_CMD  = 3'd0,
        PH_ADDR = 3'd1,
        PH_WAIT = 3'd2,
        PH_DATA = 3'd3,
        PH_SKIP = 3'd4
    } phase_e;

    // Selector value 3 falls back to one lane.
    function automatic link_e decode_link(input logic [1:0] sel);
        case (sel)
            2'd1:    return LINK_X2;
            2'd2:    return LINK_X4;
            default: return LINK_X1;
        endcase
    endfunction

    function automatic logic [2:0] lane_width(input link_e l);
        case (l)
            LINK_X2: return 3'd2;
            LINK_X4: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(input link_e l);
        case (l)
            LINK_X2: return 4'b0011;
            LINK_X4: return 4'b1111;
            default: return 4'b0010;
        endcase
    endfunction

    // Incoming bits, right-justified; lanes the width does not use are dropped.
    function automatic logic [3:0] lane_gather(input link_e l, input logic [3:0] pins);
        case (l)
            LINK_X2: return {2'b00, pins[1:0]};
            LINK_X4: return pins;
            default: return {3'b000, pins[0]};
        endcase
    endfunction

    // Bits of byte b that go out during clock number slot within the byte.
    function automatic logic [3:0] lane_slice(input link_e l, input logic [7:0] b,
                                              input logic [2:0] slot);
        logic [7:0] s;
        case (l)
            LINK_X2: begin
                s = b << {slot, 1'b0};
                return {2'b00, s[7:6]};
            end
            LINK_X4: begin
                s = b << {slot, 2'b00};
                return s[7:4];
            end
            default: begin
                s = b << slot;
                return {2'b00, s[7], 1'b0};
            end
        endcase
    endfunction

    // Index of the final clock that moves nbits at the given width.
    function automatic int unsigned last_slot(input link_e l, input int unsigned nbits);
        return nbits / int'(lane_width(l)) - 1;
    endfunction

endpackage

// File: rtl/smr_frame_fsm.sv
`timescale 1ns/1ps
module smr_frame_fsm
    import smr_pkg::*;
#(
    parameter int          ADDR_BITS  = 17,
    parameter int          ADDR_FIELD = 24,
    parameter int          IDX_W      = 10,
    parameter logic [7:0]  CMD_READ   = 8'h03,
    parameter int          WAIT_X2    = 4,
    parameter int          WAIT_X4    = 2
) (
    input  logic              sclk,
    input  logic              frame_rst,
    input  link_e             link,
    input  logic [3:0]        pins,
    output phase_e            phase,
    output logic [2:0]        slot,
    output logic [IDX_W-1:0]  rd_idx
);

    localparam int CMD_BITS = 8;
    localparam int CNT_W    = $clog2(ADDR_FIELD) + 1;

    typedef struct packed {
        phase_e                 phase;
        logic [CNT_W-1:0]       cnt;
        logic [ADDR_FIELD-1:0]  sh;
        logic [ADDR_BITS-1:0]   ptr;
    } fsm_t;

    fsm_t st_d, st_q;

    logic [ADDR_FIELD-1:0] sh_next;
    logic [CNT_W-1:0]      byte_last;
    logic [CNT_W-1:0]      addr_last;
    logic [CNT_W-1:0]      wait_last;
    int                    wait_len;

    always_comb begin
        sh_next   = (st_q.sh << lane_width(link)) | ADDR_FIELD'(lane_gather(link, pins));
        byte_last = CNT_W'(last_slot(link, CMD_BITS));
        addr_last = CNT_W'(last_slot(link, ADDR_FIELD));
        case (link)
            LINK_X2: wait_len = WAIT_X2;
            LINK_X4: wait_len = WAIT_X4;
            default: wait_len = 0;
        endcase
        wait_last = (wait_len > 0) ? CNT_W'(wait_len - 1) : '0;

        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        case (st_q.phase)
            PH_CMD: begin
                st_d.sh = sh_next;
                if (st_q.cnt == byte_last) begin
                    st_d.cnt   = '0;
                    st_d.phase = (sh_next[CMD_BITS-1:0] == CMD_READ) ? PH_ADDR : PH_SKIP;
                end
            end
            PH_ADDR: begin
                st_d.sh = sh_next;
                if (st_q.cnt == addr_last) begin
                    st_d.cnt   = '0;
                    st_d.ptr   = sh_next[ADDR_BITS-1:0];
                    st_d.phase = (wait_len == 0) ? PH_DATA : PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (st_q.cnt == wait_last) begin
                    st_d.cnt   = '0;
                    st_d.phase = PH_DATA;
                end
            end
            PH_DATA: begin
                if (st_q.cnt == byte_last) begin
                    st_d.cnt = '0;
                    st_d.ptr = st_q.ptr + 1'b1;
                end
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge sclk or posedge frame_rst) begin
        if (frame_rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase  = st_q.phase;
    assign slot   = st_q.cnt[2:0];
    assign rd_idx = st_q.ptr[IDX_W-1:0];

    // R2: an unknown command parks the frame until chip select rises
    assert_skip_sticky_R2: assert property (@(posedge sclk) disable iff (frame_rst)
        st_q.phase == PH_SKIP |=> st_q.phase == PH_SKIP);

    // R7: finishing a data byte moves the pointer by exactly one
    assert_ptr_step_R7: assert property (@(posedge sclk) disable iff (frame_rst)
        (st_q.phase == PH_DATA && st_q.cnt == byte_last)
        |=> st_q.ptr == ADDR_BITS'($past(st_q.ptr) + 1'b1));

    // R8: the top of the 17-bit space is followed by address zero
    assert_ptr_wrap_R8: assert property (@(posedge sclk) disable iff (frame_rst)
        (st_q.phase == PH_DATA && st_q.cnt == byte_last && st_q.ptr == '1)
        |=> st_q.ptr == '0);

    // R10: the clock counter never runs past the longest phase
    assert_cnt_bound_R10: assert property (@(posedge sclk) disable iff (frame_rst)
        st_q.cnt <= addr_last);

    // R4: without idle clocks, data follows the address directly
    assert_no_wait_x1_R4: assert property (@(posedge sclk) disable iff (frame_rst)
        (link == LINK_X1) |-> st_q.phase != PH_WAIT);

endmodule

// File: rtl/smr_lane_driver.sv
`timescale 1ns/1ps
module smr_lane_driver
    import smr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic              sclk,
    input  logic              frame_rst,
    input  link_e             link,
    input  phase_e            phase,
    input  logic [2:0]        slot,
    input  logic [7:0]        rd_byte,
    output logic [LANES-1:0]  dq_out,
    output logic [LANES-1:0]  dq_oe
);

    typedef struct packed {
        logic [LANES-1:0] dat;
        logic [LANES-1:0] oe;
    } drv_t;

    drv_t drv_d, drv_q;

    always_comb begin
        drv_d = '0;
        if (phase == PH_DATA) begin
            drv_d.dat = LANES'(lane_slice(link, rd_byte, slot));
            drv_d.oe  = LANES'(lane_mask(link));
        end
    end

    always_ff @(negedge sclk or posedge frame_rst) begin
        if (frame_rst) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dq_out[i] = drv_q.oe[i] & drv_q.dat[i];
        assign dq_oe[i]  = drv_q.oe[i];
    end

    // R10: lanes are enabled only while the frame is in its data phase
    assert_oe_in_data_R10: assert property (@(posedge sclk) disable iff (frame_rst)
        (dq_oe != '0) |-> phase == PH_DATA);

    // R4: the enable pattern is all-off or exactly the lanes of the width
    assert_oe_shape_R4: assert property (@(posedge sclk) disable iff (frame_rst)
        (dq_oe == '0) || (dq_oe == LANES'(lane_mask(link))));

endmodule

// File: rtl/smr_byte_store.sv
`timescale 1ns/1ps
module smr_byte_store #(
    parameter int DEPTH = 1024,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              sclk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_data
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge sclk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/serial_mem_reader.sv
`timescale 1ns/1ps
module serial_mem_reader
    import smr_pkg::*;
#(
    parameter int          DEPTH      = 1024,
    parameter int          ADDR_BITS  = 17,
    parameter int          ADDR_FIELD = 24,
    parameter logic [7:0]  CMD_READ   = 8'h03,
    parameter int          WAIT_X2    = 4,
    parameter int          WAIT_X4    = 2,
    localparam int         IDX_W      = $clog2(DEPTH)
) (
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic [1:0]        mode_sel,
    input  logic [3:0]        dq_in,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    input  logic              pl_we,
    input  logic [IDX_W-1:0]  pl_idx,
    input  logic [7:0]        pl_data
);

    logic              frame_rst;
    link_e             link;
    phase_e            phase;
    logic [2:0]        slot;
    logic [IDX_W-1:0]  rd_idx;
    logic [7:0]        rd_byte;

    assign frame_rst = cs_n | ~rst_n;
    assign link      = decode_link(mode_sel);

    smr_frame_fsm #(
        .ADDR_BITS  (ADDR_BITS),
        .ADDR_FIELD (ADDR_FIELD),
        .IDX_W      (IDX_W),
        .CMD_READ   (CMD_READ),
        .WAIT_X2    (WAIT_X2),
        .WAIT_X4    (WAIT_X4)
    ) u_fsm (
        .sclk      (sclk),
        .frame_rst (frame_rst),
        .link      (link),
        .pins      (dq_in),
        .phase     (phase),
        .slot      (slot),
        .rd_idx    (rd_idx)
    );

    smr_byte_store #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_store (
        .sclk    (sclk),
        .wr_en   (pl_we),
        .wr_idx  (pl_idx),
        .wr_data (pl_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_byte)
    );

    smr_lane_driver #(
        .LANES (4)
    ) u_drv (
        .sclk      (sclk),
        .frame_rst (frame_rst),
        .link      (link),
        .phase     (phase),
        .slot      (slot),
        .rd_byte   (rd_byte),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

endmodule

// File: tb/serial_mem_reader_tb.sv
`timescale 1ns/1ps
module serial_mem_reader_tb;

    localparam int DEPTH = 1024;
    localparam int IDX_W = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cs_n;
    logic [1:0]       mode_sel;
    logic [3:0]       dq_in;
    logic [3:0]       dq_out;
    logic [3:0]       dq_oe;
    logic             pl_we;
    logic [IDX_W-1:0] pl_idx;
    logic [7:0]       pl_data;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    serial_mem_reader #(.DEPTH(DEPTH)) u_dut (
        .rst_n    (rst_n),
        .sclk     (clk),
        .cs_n     (cs_n),
        .mode_sel (mode_sel),
        .dq_in    (dq_in),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe),
        .pl_we    (pl_we),
        .pl_idx   (pl_idx),
        .pl_data  (pl_data)
    );

    function automatic int width_of(input int mode);
        return (mode == 1) ? 2 : (mode == 2) ? 4 : 1;
    endfunction

    function automatic int wait_of(input int mode);
        return (mode == 1) ? 4 : (mode == 2) ? 2 : 0;
    endfunction

    function automatic logic [3:0] mask_of(input int mode);
        return (mode == 1) ? 4'b0011 : (mode == 2) ? 4'b1111 : 4'b0010;
    endfunction

    function automatic logic [3:0] drive_bits(input int mode, input logic [31:0] word,
                                              input int k, input logic [3:0] junk);
        logic [31:0] v;
        v = word >> (32 - width_of(mode) * (k + 1));
        if (mode == 1) return {junk[3:2], v[1:0]};
        if (mode == 2) return v[3:0];
        return {junk[3:1], v[0]};
    endfunction

    function automatic logic [7:0] take_bits(input int mode, input logic [3:0] pins);
        if (mode == 1) return {6'b0, pins[1:0]};
        if (mode == 2) return {4'b0, pins};
        return {7'b0, pins[1]};
    endfunction

    function automatic logic [7:0] expect_byte(input logic [23:0] addr, input int i);
        logic [16:0] a;
        a = addr[16:0] + 17'(i);
        return model[int'(a) % DEPTH];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic preload(input int idx, input logic [7:0] val);
        @(negedge clk);
        #1;
        pl_we   = 1'b1;
        pl_idx  = IDX_W'(idx);
        pl_data = val;
        model[idx] = val;
    endtask

    // One framed transaction; abort_mid ends it one slice into an extra byte.
    task automatic frame(input int mode, input logic [7:0] cmd, input logic [23:0] addr,
                         input int nbytes, input bit abort_mid, input string req);
        logic [31:0] word;
        int w;
        bit quiet;
        word = {cmd, addr};
        w    = width_of(mode);
        @(negedge clk);
        #1;
        mode_sel = 2'(mode);
        for (int k = 0; k < 32 / w; k++) begin
            @(negedge clk);
            #1;
            cs_n  = 1'b0;
            dq_in = drive_bits(mode, word, k, 4'($urandom));
        end
        if (cmd != 8'h03) begin
            quiet = 1'b1;
            for (int j = 0; j < 20; j++) begin
                @(negedge clk);
                #1;
                dq_in = 4'($urandom);
                #1;
                if (dq_oe != 4'b0) quiet = 1'b0;
            end
            check(quiet, "R2", "oe after unknown command", int'(dq_oe), 0);
        end else begin
            if (wait_of(mode) > 0) begin
                quiet = 1'b1;
                for (int j = 0; j < wait_of(mode); j++) begin
                    @(negedge clk);
                    #2;
                    if (dq_oe != 4'b0) quiet = 1'b0;
                end
                check(quiet, req, "oe during idle clocks (R5 R6)", int'(dq_oe), 0);
            end
            for (int i = 0; i < nbytes; i++) begin
                logic [7:0] got;
                bit oe_ok;
                got   = '0;
                oe_ok = 1'b1;
                for (int k = 0; k < 8 / w; k++) begin
                    @(negedge clk);
                    #1;
                    dq_in = 4'($urandom);
                    #1;
                    got = (got << w) | take_bits(mode, dq_out);
                    if (dq_oe != mask_of(mode)) oe_ok = 1'b0;
                end
                check(oe_ok, req, "lane enables in data (R10)", int'(dq_oe), int'(mask_of(mode)));
                check(got == expect_byte(addr, i), req, "data byte (R7 R10)",
                      int'(got), int'(expect_byte(addr, i)));
            end
            if (abort_mid) begin
                @(negedge clk);
                #1;
                dq_in = 4'($urandom);
            end
        end
        @(negedge clk);
        #1;
        cs_n = 1'b1;
        #1;
        check(dq_oe == 4'b0, "R1", "oe after chip select rises", int'(dq_oe), 0);
    endtask

    initial begin
        void'($urandom(32'd424242));
        rst_n    = 1'b0;
        cs_n     = 1'b1;
        mode_sel = 2'd0;
        dq_in    = 4'b0;
        pl_we    = 1'b0;
        pl_idx   = '0;
        pl_data  = '0;
        repeat (3) @(posedge clk);
        #2;
        check(dq_oe == 4'b0 && dq_out == 4'b0, "R1", "reset outputs", int'(dq_oe), 0);
        rst_n = 1'b1;

        // R9: fill the array through the preload port
        for (int i = 0; i < DEPTH; i++) preload(i, 8'($urandom));
        @(negedge clk);
        #1;
        pl_we = 1'b0;

        // Directed: each width, sequential bytes
        frame(0, 8'h03, 24'h000010, 4, 1'b0, "R4");
        frame(1, 8'h03, 24'h000100, 3, 1'b0, "R5");
        frame(2, 8'h03, 24'h000200, 3, 1'b0, "R6");
        frame(3, 8'h03, 24'h000033, 2, 1'b0, "R4");
        // R8: wrap of the 17-bit pointer
        frame(2, 8'h03, 24'h01FFFF, 3, 1'b0, "R8");
        frame(0, 8'h03, 24'h01FFFE, 3, 1'b0, "R8");
        // R3: upper address bits carry no weight
        frame(1, 8'h03, 24'hFE0005, 2, 1'b0, "R3");
        // R9: index is address mod DEPTH
        frame(0, 8'h03, 24'(DEPTH + 5), 1, 1'b0, "R9");
        // R2: unknown commands stay silent
        frame(0, 8'h0B, 24'h000000, 0, 1'b0, "R2");
        frame(2, 8'h02, 24'h000040, 0, 1'b0, "R2");
        // R11: abort mid-byte, then a clean frame
        frame(2, 8'h03, 24'h000080, 1, 1'b1, "R11");
        frame(0, 8'h03, 24'h000090, 2, 1'b1, "R11");
        frame(1, 8'h03, 24'h0000A0, 2, 1'b0, "R11");

        // R9: a preload is visible to the next read
        preload(7, 8'hC5);
        @(negedge clk);
        #1;
        pl_we = 1'b0;
        frame(2, 8'h03, 24'h000007, 1, 1'b0, "R9");

        for (int t = 0; t < 40; t++) begin
            int          mode;
            logic [23:0] addr;
            logic [7:0]  cmd;
            mode = int'($urandom % 4);
            addr = 24'($urandom);
            if ($urandom % 4 == 0) addr[16:0] = 17'h1FFFF - 17'($urandom % 3);
            cmd = 8'h03;
            if ($urandom % 6 == 0) begin
                cmd = 8'($urandom);
                if (cmd == 8'h03) cmd = 8'h3B;
            end
            frame(mode, cmd, addr, 1 + int'($urandom % 5), bit'($urandom % 2), "R7");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule